// File: doc/BRIEF.md
# Multi-Channel Transmit Delay and Pattern Sequencer

This block sets the firing time and the drive sequence of a group of transmit pulser channels. A serial configuration chain, clocked by its own serial clock, holds one delay code per channel and one shared divider code. When a qualified trigger is seen on the transmit clock, every channel begins counting its own delay together. Once its delay has elapsed, the channel walks through a shared pair of pattern words (a P bit and an N bit per step). It advances one step per tick of a shared clock divider, then falls back to its idle return-to-zero state.

A per-channel decoder turns the current P/N bit pair, an invert input, a continuous-wave mode input and an enable input into three drive controls: P-on, N-on and damp-to-ground. The pattern words themselves come from outside, and the analog output stage is not part of this block.

The trigger qualifier is a four-state machine. TRG_IDLE waits for the trigger. TRG_IDLE to TRG_HIGH1 is taken on the first high sample. TRG_HIGH1 to TRG_ARMED is taken on a second consecutive high sample. TRG_HIGH1 returns to TRG_IDLE on a low sample. TRG_ARMED to TRG_RUN is taken on the first low sample, and that transition is the launch. TRG_RUN returns to TRG_IDLE once every channel is idle. Each channel has a three-state machine. CH_IDLE to CH_DELAY is taken on launch when its code is not all-ones. CH_DELAY to CH_PLAY is taken when the delay count reaches its last value. CH_PLAY to CH_IDLE is taken on the divider tick that consumes the final pattern step.

Top module: `tx_beam_timer`

## Requirements
- R1: On each rising `sck` edge with `cfg_cs_n` low, the chain shifts in `cfg_din`. A word of NCH*DLY_W+DIV_W bits, sent most significant bit first, is laid out as {divider code, channel 1 delay, ..., channel NCH delay}. `cfg_dout` always shows the top bit of the chain, which after a full load is the divider code's MSB.
- R2: While `cfg_cs_n` is high, `sck` edges leave the chain and `cfg_dout` unchanged.
- R3: A launch needs `trig` sampled high on at least two consecutive `clk` edges. It occurs on the first following edge where `trig` is sampled low. A pulse sampled high on only one edge launches nothing.
- R4: A channel with delay code k (not all-ones) enters playback D = 2^DLY_W-1-k clock edges after the launch edge. Code 0 gives the longest delay, and code all-ones minus one gives 1 cycle.
- R5: A channel whose delay code is all-ones is never started. It stays in damp idle in normal mode and fully off in continuous-wave mode.
- R6: The divider ticks once every N = 2^DIV_W - code clock cycles. Its phase is cleared on the launch edge, so ticks fall on edges L+N, L+2N, and so on. Each tick during playback advances the pattern step.
- R7: Playback presents step 0 first and then steps upward. It covers PAT_MAX steps when `size_full` is 1 and PAT_MAX/2 steps when it is 0. After that the channel returns to idle, where damp is on.
- R8: With `inv` low and the channel in playback, the current bits decode as follows. P=0,N=0 gives damp only. P=1,N=0 gives P-on only. P=0,N=1 gives N-on only. P=1,N=1 gives all three off.
- R9: With `inv` high, P=1,N=0 gives N-on only and P=0,N=1 gives P-on only. The other two pairs decode as in R8.
- R10: With `cw_mode` high, a channel whose code is not all-ones drives P-on equal to a phase bit and N-on as its inverse, with damp off. The phase is cleared at launch and toggles on every divider tick. A launch in this mode starts no channel sequencer.
- R11: With `en` low, every P-on, N-on and damp-on output is 0.
- R12: A trigger that arrives while any channel is delaying or playing is ignored, and the running sequence is not restarted.
- R13: After reset the chain holds all zeros, every channel is idle, and with `en` high each channel shows damp only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial configuration clock |
| cfg_cs_n | input | 1 | Active-low chain select |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial data out for cascading |
| trig | input | 1 | Transmit trigger, synchronous to clk |
| pat_p | input | PAT_MAX | P bits of the selected pattern, step i at bit i |
| pat_n | input | PAT_MAX | N bits of the selected pattern, step i at bit i |
| size_full | input | 1 | 1 selects PAT_MAX steps, 0 selects PAT_MAX/2 |
| inv | input | 1 | Swap P and N drive in pattern mode |
| cw_mode | input | 1 | Continuous-wave mode |
| en | input | 1 | Output enable |
| p_on | output | NCH | Per-channel P driver on |
| n_on | output | NCH | Per-channel N driver on |
| damp_on | output | NCH | Per-channel damp-to-ground on |

## Verification
The bench builds the block with four channels, 4-bit delay codes, a 3-bit divider code and an 8-step pattern. With these values the longest delay is 15 cycles and the slowest divide is by 8, so a full playback at every delay extreme, including the all-ones disable code, fits in about a hundred cycles. Divide-by-1, divide-by-2 and divide-by-8 are all reachable, and both pattern lengths are covered. Each playback is compared cycle by cycle against step times computed from the launch edge, the delay code and the divide ratio.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    typedef enum logic [1:0] {
        TRG_IDLE,
        TRG_HIGH1,
        TRG_ARMED,
        TRG_RUN
    } trg_state_t;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_DELAY,
        CH_PLAY
    } ch_state_t;

    typedef struct packed {
        logic p;
        logic n;
        logic damp;
    } drive_t;

endpackage

// File: rtl/tbt_cfg_chain.sv
module tbt_cfg_chain #(
    parameter int NCH   = 8,
    parameter int DLY_W = 10,
    parameter int DIV_W = 6
) (
    input  logic                   sck,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   din,
    output logic                   dout,
    output logic [NCH*DLY_W-1:0]   dly_codes,
    output logic [DIV_W-1:0]       div_code
);
    localparam int TOTAL = NCH * DLY_W + DIV_W;

    logic [TOTAL-1:0] chain_q;

    // Shift toward the top; the oldest bit sits in the divider field.
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (!cs_n) begin
            chain_q <= {chain_q[TOTAL-2:0], din};
        end
    end

    assign dout     = chain_q[TOTAL-1];
    assign div_code = chain_q[TOTAL-1 -: DIV_W];

    for (genvar gi = 0; gi < NCH; gi++) begin : g_field
        assign dly_codes[gi*DLY_W +: DLY_W] = chain_q[TOTAL-DIV_W-1-gi*DLY_W -: DLY_W];
    end

endmodule

// File: rtl/tbt_trig_ctrl.sv
module tbt_trig_ctrl
    import tbt_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             all_idle,
    input  logic [DIV_W-1:0] div_code,
    output logic             launch,
    output logic             tick,
    output logic             cw_phase
);
    trg_state_t       state_q, state_d;
    logic [DIV_W-1:0] div_cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and launch strobe
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            TRG_IDLE: begin
                if (trig) state_d = TRG_HIGH1;
            end
            TRG_HIGH1: begin
                state_d = trig ? TRG_ARMED : TRG_IDLE;
            end
            TRG_ARMED: begin
                if (!trig) begin
                    state_d = TRG_RUN;
                    launch  = 1'b1;
                end
            end
            TRG_RUN: begin
                if (all_idle) state_d = TRG_IDLE;
            end
            default: state_d = TRG_IDLE;
        endcase
    end

    // Divide ratio is 2^DIV_W - code, so the terminal count is ~code.
    assign tick = (div_cnt_q == ~div_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
            cw_phase  <= 1'b0;
        end else if (launch) begin
            div_cnt_q <= '0;
            cw_phase  <= 1'b0;
        end else if (tick) begin
            div_cnt_q <= '0;
            cw_phase  <= ~cw_phase;
        end else begin
            div_cnt_q <= div_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tbt_channel.sv
module tbt_channel
    import tbt_pkg::*;
#(
    parameter int DLY_W   = 10,
    parameter int PAT_MAX = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               tick,
    input  logic [DLY_W-1:0]   code,
    input  logic [PAT_MAX-1:0] pat_p,
    input  logic [PAT_MAX-1:0] pat_n,
    input  logic               size_full,
    input  logic               inv,
    input  logic               cw_mode,
    input  logic               en,
    input  logic               cw_phase,
    output logic               active,
    output drive_t             drv
);
    localparam int                 IDX_W     = $clog2(PAT_MAX);
    localparam logic [DLY_W-1:0]   CNT_LAST  = DLY_W'((1 << DLY_W) - 2);
    localparam logic [IDX_W-1:0]   LAST_FULL = IDX_W'(PAT_MAX - 1);
    localparam logic [IDX_W-1:0]   LAST_HALF = IDX_W'(PAT_MAX / 2 - 1);

    ch_state_t        state_q, state_d;
    logic [DLY_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic             code_off;
    logic             bit_p, bit_n;

    assign code_off = &code;
    assign last_idx = size_full ? LAST_FULL : LAST_HALF;
    assign bit_p    = pat_p[idx_q];
    assign bit_n    = pat_n[idx_q];
    assign active   = (state_q != CH_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (start && !code_off) state_d = CH_DELAY;
            end
            CH_DELAY: begin
                if (cnt_q == CNT_LAST) state_d = CH_PLAY;
            end
            CH_PLAY: begin
                if (tick && (idx_q == last_idx)) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Delay counter and step index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            if (state_q == CH_IDLE && start) begin
                cnt_q <= code;
            end else if (state_q == CH_DELAY) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == CH_DELAY && state_d == CH_PLAY) begin
                idx_q <= '0;
            end else if (state_q == CH_PLAY && tick) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        drv = '0;
        if (!en) begin
            drv = '0;
        end else if (cw_mode) begin
            if (!code_off) begin
                drv.p = cw_phase;
                drv.n = ~cw_phase;
            end
        end else if (state_q == CH_PLAY) begin
            unique case ({bit_p, bit_n})
                2'b00: drv.damp = 1'b1;
                2'b10: begin
                    drv.p = ~inv;
                    drv.n = inv;
                end
                2'b01: begin
                    drv.p = inv;
                    drv.n = ~inv;
                end
                default: drv = '0;
            endcase
        end else begin
            drv.damp = 1'b1;
        end
    end

endmodule

// File: rtl/tx_beam_timer.sv
module tx_beam_timer
    import tbt_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int DLY_W   = 10,
    parameter int DIV_W   = 6,
    parameter int PAT_MAX = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cfg_cs_n,
    input  logic               cfg_din,
    output logic               cfg_dout,
    input  logic               trig,
    input  logic [PAT_MAX-1:0] pat_p,
    input  logic [PAT_MAX-1:0] pat_n,
    input  logic               size_full,
    input  logic               inv,
    input  logic               cw_mode,
    input  logic               en,
    output logic [NCH-1:0]     p_on,
    output logic [NCH-1:0]     n_on,
    output logic [NCH-1:0]     damp_on
);
    logic [NCH*DLY_W-1:0] dly_codes;
    logic [DIV_W-1:0]     div_code;
    logic                 launch;
    logic                 tick;
    logic                 cw_phase;
    logic [NCH-1:0]       ch_busy;
    logic                 all_idle;
    logic                 ch_start;
    drive_t               drv [NCH];

    assign all_idle = ~|ch_busy;
    assign ch_start = launch & ~cw_mode;

    tbt_cfg_chain #(
        .NCH   (NCH),
        .DLY_W (DLY_W),
        .DIV_W (DIV_W)
    ) u_chain (
        .sck       (sck),
        .rst_n     (rst_n),
        .cs_n      (cfg_cs_n),
        .din       (cfg_din),
        .dout      (cfg_dout),
        .dly_codes (dly_codes),
        .div_code  (div_code)
    );

    tbt_trig_ctrl #(
        .DIV_W (DIV_W)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .all_idle (all_idle),
        .div_code (div_code),
        .launch   (launch),
        .tick     (tick),
        .cw_phase (cw_phase)
    );

    for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
        tbt_channel #(
            .DLY_W   (DLY_W),
            .PAT_MAX (PAT_MAX)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (ch_start),
            .tick      (tick),
            .code      (dly_codes[gc*DLY_W +: DLY_W]),
            .pat_p     (pat_p),
            .pat_n     (pat_n),
            .size_full (size_full),
            .inv       (inv),
            .cw_mode   (cw_mode),
            .en        (en),
            .cw_phase  (cw_phase),
            .active    (ch_busy[gc]),
            .drv       (drv[gc])
        );
        assign p_on[gc]    = drv[gc].p;
        assign n_on[gc]    = drv[gc].n;
        assign damp_on[gc] = drv[gc].damp;
    end

endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           sck,
    input logic           rst_n,
    input logic           cfg_cs_n,
    input logic           cfg_dout,
    input logic           trig,
    input logic           en,
    input logic           cw_mode,
    input logic           launch,
    input logic [NCH-1:0] ch_busy,
    input logic [NCH-1:0] p_on,
    input logic [NCH-1:0] n_on,
    input logic [NCH-1:0] damp_on
);

    AST_CHAIN_HOLD: assert property (@(posedge sck) disable iff (!rst_n)
        cfg_cs_n |=> $stable(cfg_dout)); // R2

    AST_LAUNCH_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!trig && $past(trig) && $past(trig, 2))); // R3

    AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_busy) |-> !launch); // R12

    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ((p_on == '0) && (n_on == '0) && (damp_on == '0))); // R11

    for (genvar gk = 0; gk < NCH; gk++) begin : g_chk
        AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({p_on[gk], n_on[gk], damp_on[gk]})); // R8

        AST_IDLE_DAMP: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !cw_mode && !ch_busy[gk]) |-> damp_on[gk]); // R7
    end

endmodule

bind tx_beam_timer tbt_checker #(
    .NCH (NCH)
) u_chk (
    .clk      (clk),
    .sck      (sck),
    .rst_n    (rst_n),
    .cfg_cs_n (cfg_cs_n),
    .cfg_dout (cfg_dout),
    .trig     (trig),
    .en       (en),
    .cw_mode  (cw_mode),
    .launch   (launch),
    .ch_busy  (ch_busy),
    .p_on     (p_on),
    .n_on     (n_on),
    .damp_on  (damp_on)
);

// File: tb/tx_beam_timer_bench.sv
module tx_beam_timer_bench;
    localparam int NCH     = 4;
    localparam int DLY_W   = 4;
    localparam int DIV_W   = 3;
    localparam int PAT_MAX = 8;
    localparam int TOTAL   = NCH * DLY_W + DIV_W;
    localparam int DMAX    = (1 << DLY_W) - 1;

    localparam int M_PLAY = 0;
    localparam int M_CW   = 1;
    localparam int M_IDLE = 2;
    localparam int M_OFF  = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sck = 1'b0;
    logic               cfg_cs_n = 1'b1;
    logic               cfg_din = 1'b0;
    logic               cfg_dout;
    logic               trig = 1'b0;
    logic [PAT_MAX-1:0] pat_p = '0;
    logic [PAT_MAX-1:0] pat_n = '0;
    logic               size_full = 1'b0;
    logic               inv = 1'b0;
    logic               cw_mode = 1'b0;
    logic               en = 1'b1;
    logic [NCH-1:0]     p_on, n_on, damp_on;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int codes [NCH];
    int dcode;

    always #4 clk = ~clk;

    tx_beam_timer #(
        .NCH (NCH), .DLY_W (DLY_W), .DIV_W (DIV_W), .PAT_MAX (PAT_MAX)
    ) u_tx_beam_timer (
        .clk (clk), .rst_n (rst_n), .sck (sck), .cfg_cs_n (cfg_cs_n),
        .cfg_din (cfg_din), .cfg_dout (cfg_dout), .trig (trig),
        .pat_p (pat_p), .pat_n (pat_n), .size_full (size_full), .inv (inv),
        .cw_mode (cw_mode), .en (en), .p_on (p_on), .n_on (n_on),
        .damp_on (damp_on)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [TOTAL-1:0] build_word();
        logic [TOTAL-1:0] w;
        w = '0;
        w[TOTAL-1 -: DIV_W] = DIV_W'(dcode);
        for (int i = 0; i < NCH; i++)
            w[TOTAL-DIV_W-1-i*DLY_W -: DLY_W] = DLY_W'(codes[i]);
        return w;
    endfunction

    task automatic sck_pulse(input logic d);
        cfg_din = d;
        #10 sck = 1'b1;
        #10 sck = 1'b0;
    endtask

    task automatic load_chain();
        logic [TOTAL-1:0] w;
        w = build_word();
        cfg_cs_n = 1'b0;
        for (int i = TOTAL - 1; i >= 0; i--) sck_pulse(w[i]);
        cfg_cs_n = 1'b1;
        #10;
    endtask

    // Expected {p,n,damp} for channel c, t edges after the launch edge
    function automatic logic [2:0] exp_drv(input int c, input int t, input int mode);
        int n_div, d, s, steps;
        logic pb, nb;
        n_div = (1 << DIV_W) - dcode;
        if (mode == M_OFF) return 3'b000;
        if (mode == M_IDLE) return 3'b001;
        if (mode == M_CW) begin
            if (codes[c] == DMAX) return 3'b000;
            return ((t / n_div) % 2 == 1) ? 3'b100 : 3'b010;
        end
        if (codes[c] == DMAX) return 3'b001;
        d = DMAX - codes[c];
        if (t < d) return 3'b001;
        s = t / n_div - d / n_div;
        steps = size_full ? PAT_MAX : PAT_MAX / 2;
        if (s >= steps) return 3'b001;
        pb = pat_p[s];
        nb = pat_n[s];
        case ({pb, nb})
            2'b00:   return 3'b001;
            2'b10:   return inv ? 3'b010 : 3'b100;
            2'b01:   return inv ? 3'b100 : 3'b010;
            default: return 3'b000;
        endcase
    endfunction

    // trig high for hi_edges rising edges, then low; returns just after launch edge
    task automatic fire(input int hi_edges);
        @(negedge clk);
        trig = 1'b1;
        repeat (hi_edges) @(posedge clk);
        @(negedge clk);
        trig = 1'b0;
        @(posedge clk);
    endtask

    task automatic run_check(input string req, input int ncyc, input int mode);
        logic [3*NCH-1:0] act, exp;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                act[3*c +: 3] = {p_on[c], n_on[c], damp_on[c]};
                exp[3*c +: 3] = exp_drv(c, t, mode);
            end
            check(act == exp, $sformatf("%s cycle %0d", req, t), act, exp);
            @(posedge clk);
        end
    endtask

    task automatic t_reset();
        logic [3*NCH-1:0] act, exp;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            act[3*c +: 3] = {p_on[c], n_on[c], damp_on[c]};
            exp[3*c +: 3] = 3'b001;
        end
        check(act == exp, "R13 reset drive state", act, exp);
        check(cfg_dout == 1'b0, "R13 reset chain output", cfg_dout, 0);
    endtask

    task automatic t_chain();
        logic [TOTAL-1:0] w;
        codes = '{0, 14, 7, 15};
        dcode = 6;
        w = build_word();
        load_chain();
        check(cfg_dout == w[TOTAL-1], "R1 dout after full load", cfg_dout, w[TOTAL-1]);
        cfg_cs_n = 1'b0;
        sck_pulse(1'b0);
        cfg_cs_n = 1'b1;
        #10;
        check(cfg_dout == w[TOTAL-2], "R1 dout after one extra shift", cfg_dout, w[TOTAL-2]);
        sck_pulse(~w[TOTAL-3]);
        sck_pulse(~w[TOTAL-3]);
        sck_pulse(~w[TOTAL-3]);
        #10;
        check(cfg_dout == w[TOTAL-2], "R2 dout held while deselected", cfg_dout, w[TOTAL-2]);
        load_chain();
    endtask

    task automatic t_play_half();
        // step0 P, step1 N, step2 damp, step3 off; N=2
        pat_p = 8'b1010_1001;
        pat_n = 8'b0101_1010;
        size_full = 1'b0;
        inv = 1'b0;
        fire(2);
        run_check("R4 R5 R6 R7 R8 half pattern div2", 60, M_PLAY);
    endtask

    task automatic t_play_full();
        codes = '{13, 3, 15, 9};
        dcode = 7;
        load_chain();
        size_full = 1'b1;
        fire(3);
        run_check("R4 R6 R7 full pattern div1", 40, M_PLAY);
    endtask

    task automatic t_invert();
        codes = '{14, 12, 10, 8};
        dcode = 0;
        load_chain();
        size_full = 1'b0;
        inv = 1'b1;
        fire(2);
        run_check("R9 inverted pattern div8", 60, M_PLAY);
        inv = 1'b0;
    endtask

    task automatic t_short_trig();
        fire(1);
        run_check("R3 single-edge trigger ignored", 30, M_IDLE);
    endtask

    task automatic t_retrig();
        codes = '{0, 2, 5, 11};
        dcode = 5;
        load_chain();
        size_full = 1'b1;
        fire(2);
        fork
            run_check("R12 retrigger during playback", 70, M_PLAY);
            begin
                repeat (10) @(negedge clk);
                trig = 1'b1;
                repeat (3) @(posedge clk);
                @(negedge clk);
                trig = 1'b0;
            end
        join
        run_check("R12 no launch after retrigger", 20, M_IDLE);
    endtask

    task automatic t_cw();
        codes = '{4, 14, 9, 15};
        dcode = 6;
        load_chain();
        cw_mode = 1'b1;
        fire(2);
        run_check("R10 R5 continuous wave", 30, M_CW);
        cw_mode = 1'b0;
        run_check("R10 no sequencer started in cw", 5, M_IDLE);
    endtask

    task automatic t_enable();
        en = 1'b0;
        fire(2);
        run_check("R11 enable low forces off", 40, M_OFF);
        en = 1'b1;
        run_check("R11 enable restored idle", 5, M_IDLE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chain();
        t_play_half();
        t_play_full();
        t_invert();
        t_short_trig();
        t_retrig();
        t_cw();
        t_enable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule